// File: doc/BRIEF.md
# Reconfiguration Instruction Coprocessor

This block sits beside a small RISC-V core and carries out three custom transfer instructions that move configuration data. The core hands over the instruction word and its two operand values through a valid/ready dispatch and keeps its pipeline stalled until the coprocessor answers. The answer is a single-cycle ready pulse together with a 32-bit result that the core writes back to its register file.

Inside are a control state machine, a local word buffer and an input FIFO. The transfers are: buffer to port (write-config), port to buffer (read-config) and FIFO to port (write-bitstream). The configuration port is a plain 32-bit word interface with one write strobe and one read strobe. External logic, typically a flash reader, fills the FIFO through a simple push interface. Operand A carries the buffer start address (for write-bitstream, an external address that the FIFO path does not use). Operand B carries the word count.

Top module: `cfg_coproc`

## Requirements
- R1: An instruction is recognised only when bits [6:0] equal 7'b0101011, bits [14:12] equal 3'b111 (rd, rs1 and rs2 all in use) and bits [31:25] equal 0 (write-config), 1 (read-config) or 2 (write-bitstream). The low AW bits of operand A give the buffer address, and the low CNT_W bits of operand B give the word count.
- R2: Write-config with count N>0 asserts port_wr for exactly N consecutive cycles, starting in the cycle after the accepting edge. port_wdata carries the buffer words from address A upward, with the address wrapping modulo BUF_DEPTH.
- R3: Read-config with count N>0 asserts port_rd for exactly N consecutive cycles and never together with port_wr. In each of those cycles, the port_rdata present is stored at the next buffer address, starting at A and wrapping.
- R4: Write-bitstream sends FIFO words to the port in push order. While the FIFO is empty it waits without counting, and port_wr is high only in cycles that carry a FIFO word.
- R5: A push while the FIFO holds FIFO_DEPTH words is dropped, and fifo_full is high exactly while FIFO_DEPTH words are held. FIFO_DEPTH must be a power of two.
- R6: Every instruction ends with disp_ready high for exactly one cycle. For a transfer, disp_result then equals the number of words moved.
- R7: An unrecognised instruction gives disp_ready in the cycle after the accepting edge and disp_result = 32'hFFFF_FFFF, with no port activity.
- R8: A word count of zero gives disp_ready in the cycle after the accepting edge and disp_result = 0, with no port activity.
- R9: After reset, disp_ready, port_wr, port_rd and fifo_full are low and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Core presents an instruction; held until disp_ready |
| disp_insn | input | 32 | Instruction word |
| disp_op_a | input | 32 | First operand value (address) |
| disp_op_b | input | 32 | Second operand value (word count) |
| disp_ready | output | 1 | One-cycle completion pulse |
| disp_result | output | 32 | Value for the destination register |
| fifo_push | input | 1 | Push strobe of the input FIFO |
| fifo_data | input | 32 | Word to push |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH words |
| port_wr | output | 1 | Configuration port write strobe |
| port_wdata | output | 32 | Configuration port write word |
| port_rd | output | 1 | Configuration port read strobe |
| port_rdata | input | 32 | Configuration port read word, valid while port_rd is high |

## Verification
The hardest case to reach is a write-bitstream that runs dry partway through, so that the state machine must hold its count across empty cycles and resume without losing or duplicating a word. The bench starts such a transfer with only part of the words queued and feeds the rest from a parallel process with gaps, so the monitor sees the stalls and still has to match every word in push order. The full FIFO is reached by pushing past its depth with no consumer active. A later single-word transfer then shows that the dropped words never reach the port.

// File: rtl/cfg_coproc.sv
module cfg_coproc #(
  parameter int BUF_DEPTH  = 64,
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        disp_valid,
  input  logic [31:0] disp_insn,
  input  logic [31:0] disp_op_a,
  input  logic [31:0] disp_op_b,
  output logic        disp_ready,
  output logic [31:0] disp_result,
  input  logic        fifo_push,
  input  logic [31:0] fifo_data,
  output logic        fifo_full,
  output logic        port_wr,
  output logic [31:0] port_wdata,
  output logic        port_rd,
  input  logic [31:0] port_rdata
);
  localparam int AW = $clog2(BUF_DEPTH);
  localparam int FW = $clog2(FIFO_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;
  typedef enum logic [1:0] {M_WCFG, M_RCFG, M_WBIT} mode_t;

  state_t           state;
  mode_t            mode;
  logic [AW-1:0]    addr;
  logic [CNT_W-1:0] left, moved, moved_nxt, cnt_in;
  logic [31:0]      res;
  logic [31:0]      bufm [BUF_DEPTH];
  logic [31:0]      fmem [FIFO_DEPTH];
  logic [FW:0]      wptr, rptr;
  logic             fifo_empty, pop, step, legal, accept;
  logic             unused_bits;

  assign unused_bits = ^{disp_op_a[31:AW], disp_op_b[31:CNT_W], disp_insn[24:15], disp_insn[11:7]};

  assign legal  = disp_insn[6:0] == 7'b0101011 && disp_insn[14:12] == 3'b111 && disp_insn[31:25] <= 7'd2;
  assign accept = state == S_IDLE && disp_valid;
  assign cnt_in = disp_op_b[CNT_W-1:0];
  assign moved_nxt = moved + 1'b1;

  assign fifo_empty = wptr == rptr;
  assign fifo_full  = wptr[FW] != rptr[FW] && wptr[FW-1:0] == rptr[FW-1:0];

  assign port_rd    = state == S_RUN && mode == M_RCFG;
  assign port_wr    = state == S_RUN && (mode == M_WCFG || (mode == M_WBIT && !fifo_empty));
  assign port_wdata = mode == M_WBIT ? fmem[rptr[FW-1:0]] : bufm[addr];
  assign pop        = port_wr && mode == M_WBIT;
  assign step       = port_wr || port_rd;

  assign disp_ready  = state == S_DONE;
  assign disp_result = res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      mode  <= M_WCFG;
      addr  <= '0;
      left  <= '0;
      moved <= '0;
      res   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          if (!legal) begin
            res   <= '1;
            state <= S_DONE;
          end else if (cnt_in == '0) begin
            res   <= '0;
            state <= S_DONE;
          end else begin
            mode  <= mode_t'(disp_insn[26:25]);
            addr  <= disp_op_a[AW-1:0];
            left  <= cnt_in;
            moved <= '0;
            state <= S_RUN;
          end
        end
        S_RUN: if (step) begin
          addr  <= addr + 1'b1;
          moved <= moved_nxt;
          left  <= left - 1'b1;
          if (left == CNT_W'(1)) begin
            res   <= 32'(moved_nxt);
            state <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (port_rd) bufm[addr] <= port_rdata;

  always_ff @(posedge clk)
    if (fifo_push && !fifo_full) fmem[wptr[FW-1:0]] <= fifo_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (fifo_push && !fifo_full) wptr <= wptr + 1'b1;
      if (pop) rptr <= rptr + 1'b1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(port_wr && port_rd)); // R3
  AST_NO_EMPTY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (port_wr && mode == M_WBIT) |-> !fifo_empty); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (fifo_full && !pop) |=> $stable(wptr)); // R5
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) disp_ready |=> !disp_ready); // R6
  AST_ILLEGAL_FAST: assert property (@(posedge clk) disable iff (!rst_n) (disp_ready && disp_result == '1) |-> $past(state) == S_IDLE); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (state != S_RUN) |-> (!port_wr && !port_rd)); // R8
endmodule

// File: tb/test_cfg_coproc.sv
module test_cfg_coproc;
  localparam int BD = 64;
  localparam int FD = 16;

  logic clk = 0, rst_n = 0;
  logic disp_valid = 0;
  logic [31:0] disp_insn = 0, disp_op_a = 0, disp_op_b = 0;
  logic disp_ready;
  logic [31:0] disp_result;
  logic fifo_push = 0;
  logic [31:0] fifo_data = 0;
  logic fifo_full, port_wr, port_rd;
  logic [31:0] port_wdata, port_rdata;
  int rd_idx = 0;

  cfg_coproc #(.BUF_DEPTH(BD), .FIFO_DEPTH(FD), .CNT_W(16)) i_cfg_coproc (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_insn(disp_insn),
    .disp_op_a(disp_op_a), .disp_op_b(disp_op_b), .disp_ready(disp_ready),
    .disp_result(disp_result), .fifo_push(fifo_push), .fifo_data(fifo_data),
    .fifo_full(fifo_full), .port_wr(port_wr), .port_wdata(port_wdata),
    .port_rd(port_rd), .port_rdata(port_rdata));

  always #2 clk = ~clk;

  assign port_rdata = 32'hA500_0000 + 32'(rd_idx);
  always @(posedge clk) if (port_rd) rd_idx <= rd_idx + 1;

  int checks = 0, fails = 0, nrd = 0, rd_total = 0;
  logic [31:0] wq[$];
  logic [31:0] resq[$];
  logic [31:0] mbuf [BD];

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && port_wr) begin
      if (wq.size() == 0) chk(0, "R2/R4/R7/R8 unexpected port write", port_wdata, 32'hx);
      else begin
        logic [31:0] e;
        e = wq.pop_front();
        chk(port_wdata == e, "R2/R4 port word", port_wdata, e);
      end
    end
    if (rst_n && port_rd) nrd++;
    if (rst_n && disp_ready) begin
      if (resq.size() == 0) chk(0, "R6 unexpected ready", disp_result, 32'hx);
      else begin
        logic [31:0] e;
        e = resq.pop_front();
        chk(disp_result == e, "R6 result", disp_result, e);
      end
    end
  end

  task automatic run_insn(input logic [6:0] f7, input logic [2:0] f3, input logic [6:0] opc,
                          input logic [31:0] a, input logic [31:0] b, input logic [31:0] exp_res,
                          input int exp_lat, input int exp_rd, input string req);
    int lat, rd0;
    lat = 0;
    rd0 = nrd;
    resq.push_back(exp_res);
    @(negedge clk);
    disp_insn = {f7, 5'd2, 5'd1, f3, 5'd3, opc};
    disp_op_a = a;
    disp_op_b = b;
    disp_valid = 1;
    do begin
      @(negedge clk);
      lat++;
    end while (!disp_ready);
    disp_valid = 0;
    if (exp_lat > 0) chk(lat == exp_lat, {req, " latency"}, 32'(lat), 32'(exp_lat));
    @(negedge clk);
    chk(!disp_ready, "R6 ready single cycle", 32'(disp_ready), 0);
    chk(nrd - rd0 == exp_rd, {req, " read strobe count"}, 32'(nrd - rd0), 32'(exp_rd));
  endtask

  task automatic rcfg(input int a, input int n);
    for (int k = 0; k < n; k++) mbuf[(a + k) % BD] = 32'hA500_0000 + 32'(rd_total + k);
    rd_total += n;
    run_insn(7'd1, 3'b111, 7'b0101011, 32'(a), 32'(n), 32'(n), n + 1, n, "R3 read-config");
  endtask

  task automatic wcfg(input int a, input int n);
    for (int k = 0; k < n; k++) wq.push_back(mbuf[(a + k) % BD]);
    run_insn(7'd0, 3'b111, 7'b0101011, 32'(a), 32'(n), 32'(n), n + 1, 0, "R2 write-config");
  endtask

  task automatic push_word(input logic [31:0] d);
    @(negedge clk);
    if (!fifo_full) wq.push_back(d);
    fifo_push = 1;
    fifo_data = d;
    @(negedge clk);
    fifo_push = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!disp_ready && !port_wr && !port_rd, "R9 reset strobes", {port_rd, port_wr, disp_ready}, 0);
    chk(!fifo_full, "R9 reset fifo_full", 32'(fifo_full), 0);

    rcfg(4, 5);
    wcfg(4, 5);
    rcfg(BD - 2, 4);
    wcfg(BD - 2, 4);
    wcfg(5, 2);

    run_insn(7'd0, 3'b111, 7'b0101011, 32'd4, 32'd0, 32'd0, 1, 0, "R8 zero write-config");
    run_insn(7'd1, 3'b111, 7'b0101011, 32'd4, 32'd0, 32'd0, 1, 0, "R8 zero read-config");
    run_insn(7'd2, 3'b111, 7'b0101011, 32'd0, 32'd0, 32'd0, 1, 0, "R8 zero write-bitstream");
    run_insn(7'd5, 3'b111, 7'b0101011, 32'd4, 32'd3, 32'hFFFF_FFFF, 1, 0, "R7 R1 bad funct7");
    run_insn(7'd0, 3'b111, 7'b0001011, 32'd4, 32'd3, 32'hFFFF_FFFF, 1, 0, "R7 R1 bad opcode");
    run_insn(7'd1, 3'b011, 7'b0101011, 32'd4, 32'd3, 32'hFFFF_FFFF, 1, 0, "R7 R1 bad funct3");
    wcfg(4, 5);

    for (int k = 0; k < 3; k++) push_word(32'hB000_0000 + 32'(k));
    fork
      run_insn(7'd2, 3'b111, 7'b0101011, 32'h1234, 32'd6, 32'd6, 0, 0, "R4 write-bitstream stall");
      begin
        repeat (6) @(negedge clk);
        for (int k = 3; k < 6; k++) begin
          push_word(32'hB000_0000 + 32'(k));
          repeat (2) @(negedge clk);
        end
      end
    join
    chk(wq.size() == 0, "R4 all bitstream words sent", 32'(wq.size()), 0);

    for (int k = 0; k < FD + 2; k++) push_word(32'hC000_0000 + 32'(k));
    chk(fifo_full, "R5 fifo_full at depth", 32'(fifo_full), 1);
    run_insn(7'd2, 3'b111, 7'b0101011, 32'd0, 32'(FD), 32'(FD), FD + 1, 0, "R4 R5 drain full FIFO");
    chk(!fifo_full, "R5 fifo_full after drain", 32'(fifo_full), 0);
    push_word(32'hD00D_0001);
    run_insn(7'd2, 3'b111, 7'b0101011, 32'd0, 32'd1, 32'd1, 2, 0, "R5 dropped words absent");

    repeat (3) @(negedge clk);
    chk(wq.size() == 0, "R2/R4 expected writes pending", 32'(wq.size()), 0);
    chk(resq.size() == 0, "R6 results pending", 32'(resq.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule